// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits behind the register write path of a storage host controller and handles the stores that land in the doorbell window. It keeps a small record for each queue index: whether the submission side and the completion side exist, how many entries each has, and which completion queue each submission queue reports to. A write to a doorbell moves the submission tail or the completion head of that queue. Writes that are malformed, that fall outside the window, or that point at a missing queue are dropped with no error.

Queue management logic creates and deletes queues through a configuration strobe. A create loads the entry count and sets the pointer to zero. A delete turns the queue off. The completion posting engine supplies the current tail of every completion queue. A one-cycle kick per submission queue tells the fetch engine to look at that queue. A one-cycle interrupt request per completion queue reports that host-visible completions are still pending after the host moved its head.

Top module: `doorbell_decoder`

## Requirements
- R1: After reset every submission tail and completion head output is 0, no kick or interrupt is pulsed, and no queue exists, so every doorbell write is dropped until a queue is created.
- R2: A write at address 0x1000 + 8*q (address bit 2 clear) to an existing submission queue q sets its tail to the written pointer and pulses sq_kick[q] for exactly the cycle after the write.
- R3: A write at address 0x1004 + 8*q (address bit 2 set) to an existing completion queue q sets its head to the written pointer, with the new value visible the cycle after the write.
- R4: A write whose address bits [1:0] are not 00 changes no pointer and raises no pulse.
- R5: A write below address 0x1000 changes no pointer and raises no pulse.
- R6: A write whose queue index ((address - 0x1000) >> 3) is NUM_Q or higher, or whose addressed queue side does not exist, changes nothing.
- R7: A pointer value equal to or greater than the addressed queue's entry count is dropped.
- R8: Only wr_data[15:0] forms the pointer; wr_data[31:16] has no effect.
- R9: If a completion queue was full before an accepted head write, meaning (tail + 1) modulo its entry count equals the old head, then every existing submission queue bound to it gets a kick in the cycle after the write, and no other queue does.
- R10: After an accepted head write, cq_irq[q] pulses for one cycle when the new head differs from cq_tail_in for q, and stays low when they are equal.
- R11: A create loads the entry count and sets the pointer of that side to 0, and for a submission queue it also records the bound completion queue. A delete makes later doorbells to that side be dropped.
- R12: Kicks and interrupts stay low in any cycle that does not follow an accepted doorbell write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data; the low 16 bits are the pointer |
| cfg_en | input | 1 | Queue create/delete strobe |
| cfg_is_cq | input | 1 | 1 = completion side, 0 = submission side |
| cfg_create | input | 1 | 1 = create, 0 = delete |
| cfg_qid | input | QID_W | Queue index being configured |
| cfg_size | input | 16 | Entry count loaded on create |
| cfg_cqid | input | QID_W | Bound completion queue (submission create only) |
| cq_tail_in | input | NUM_Q*16 | Completion tails from the posting engine, queue q in bits [16q+15:16q] |
| sq_tail_out | output | NUM_Q*16 | Submission tails, same packing |
| cq_head_out | output | NUM_Q*16 | Completion heads, same packing |
| sq_kick | output | NUM_Q | One-cycle fetch request per submission queue |
| cq_irq | output | NUM_Q | One-cycle interrupt request per completion queue |

## Verification
The properties assume wr_en and cfg_en are low while reset is held, that a configuration strobe and a doorbell write never reach the same cycle, and that each cq_tail_in slice stays below its queue's entry count. The stimulus issues one operation per clock, with idle cycles between them. It keeps the configuration and doorbell phases apart, and it changes completion tails only through legal values for the queue being exercised. The full-queue restart is forced by placing the supplied tail one slot behind the head, and bound and unbound queues are compared in the same cycle.

// File: rtl/db_pkg.sv
package db_pkg;

    localparam int PTR_W = 16;
    localparam logic [15:0] DB_BASE = 16'h1000;

    typedef enum logic {
        DB_SQ_TAIL = 1'b0,
        DB_CQ_HEAD = 1'b1
    } db_kind_e;

    typedef struct packed {
        logic             hit;
        db_kind_e         kind;
        logic [15:0]      qid;
        logic [PTR_W-1:0] ptr;
    } db_req_t;

    typedef struct packed {
        logic             en;
        logic             is_cq;
        logic             create;
        logic [15:0]      qid;
        logic [PTR_W-1:0] size;
        logic [15:0]      cqid;
    } db_cfg_t;

    function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p,
                                                   input logic [PTR_W-1:0] size);
        logic [PTR_W:0] nxt;
        nxt = {1'b0, p} + 1'b1;
        return (nxt >= {1'b0, size}) ? '0 : nxt[PTR_W-1:0];
    endfunction

endpackage

// File: rtl/db_addr_decode.sv
module db_addr_decode
    import db_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output db_req_t           req
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(DB_BASE);
    localparam logic [ADDR_W-1:0] QLIM   = ADDR_W'(NUM_Q);

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] idx;
    logic              in_window;
    logic              aligned;

    always_comb begin
        off       = wr_addr - BASE_A;
        idx       = off >> 3;
        in_window = (wr_addr >= BASE_A) && (idx < QLIM);
        aligned   = (wr_addr[1:0] == 2'b00);
        req.hit   = wr_en && in_window && aligned;
        req.kind  = off[2] ? DB_CQ_HEAD : DB_SQ_TAIL;
        req.qid   = 16'(idx);
        req.ptr   = wr_data[PTR_W-1:0];
    end

endmodule

// File: rtl/db_queue_slot.sv
module db_queue_slot
    import db_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  db_cfg_t          cfg,
    input  db_req_t          req,
    input  logic [PTR_W-1:0] cq_tail,
    input  logic             restart_en,
    input  logic [15:0]      restart_cqid,
    output logic [PTR_W-1:0] sq_tail,
    output logic [PTR_W-1:0] cq_head,
    output logic             kick,
    output logic             irq,
    output logic             cq_take,
    output logic             cq_full
);
    logic             sq_live, cq_live;
    logic [PTR_W-1:0] sq_len, cq_len;
    logic [15:0]      sq_bind;
    logic             mine, cfg_mine, sq_take, restart_me;

    always_comb begin
        mine       = req.hit && (req.qid == 16'(IDX));
        cfg_mine   = cfg.en && (cfg.qid == 16'(IDX));
        sq_take    = mine && (req.kind == DB_SQ_TAIL) && sq_live && (req.ptr < sq_len);
        cq_take    = mine && (req.kind == DB_CQ_HEAD) && cq_live && (req.ptr < cq_len);
        cq_full    = cq_live && (ring_next(cq_tail, cq_len) == cq_head);
        restart_me = restart_en && sq_live && (sq_bind == restart_cqid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_live <= 1'b0;
            cq_live <= 1'b0;
            sq_len  <= '0;
            cq_len  <= '0;
            sq_bind <= '0;
            sq_tail <= '0;
            cq_head <= '0;
            kick    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            kick <= 1'b0;
            irq  <= 1'b0;
            if (cfg_mine) begin
                if (cfg.is_cq) begin
                    cq_live <= cfg.create;
                    cq_len  <= cfg.size;
                    cq_head <= '0;
                end else begin
                    sq_live <= cfg.create;
                    sq_len  <= cfg.size;
                    sq_bind <= cfg.cqid;
                    sq_tail <= '0;
                end
            end else begin
                if (sq_take) begin
                    sq_tail <= req.ptr;
                    kick    <= 1'b1;
                end
                if (cq_take) begin
                    cq_head <= req.ptr;
                    irq     <= (req.ptr != cq_tail);
                end
                if (restart_me) begin
                    kick <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/doorbell_decoder.sv
module doorbell_decoder
    import db_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int ADDR_W = 16,
    parameter int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    input  logic                   cfg_en,
    input  logic                   cfg_is_cq,
    input  logic                   cfg_create,
    input  logic [QID_W-1:0]       cfg_qid,
    input  logic [15:0]            cfg_size,
    input  logic [QID_W-1:0]       cfg_cqid,
    input  logic [NUM_Q*PTR_W-1:0] cq_tail_in,
    output logic [NUM_Q*PTR_W-1:0] sq_tail_out,
    output logic [NUM_Q*PTR_W-1:0] cq_head_out,
    output logic [NUM_Q-1:0]       sq_kick,
    output logic [NUM_Q-1:0]       cq_irq
);
    db_req_t          req;
    db_cfg_t          cfg;
    logic [NUM_Q-1:0] take_v;
    logic [NUM_Q-1:0] full_v;
    logic             restart_en;

    always_comb begin
        cfg.en     = cfg_en;
        cfg.is_cq  = cfg_is_cq;
        cfg.create = cfg_create;
        cfg.qid    = 16'(cfg_qid);
        cfg.size   = cfg_size;
        cfg.cqid   = 16'(cfg_cqid);
        restart_en = |(take_v & full_v);
    end

    db_addr_decode #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
        db_queue_slot #(.IDX(q)) u_slot (
            .clk          (clk),
            .rst          (rst),
            .cfg          (cfg),
            .req          (req),
            .cq_tail      (cq_tail_in[q*PTR_W +: PTR_W]),
            .restart_en   (restart_en),
            .restart_cqid (req.qid),
            .sq_tail      (sq_tail_out[q*PTR_W +: PTR_W]),
            .cq_head      (cq_head_out[q*PTR_W +: PTR_W]),
            .kick         (sq_kick[q]),
            .irq          (cq_irq[q]),
            .cq_take      (take_v[q]),
            .cq_full      (full_v[q])
        );
    end

endmodule

// File: rtl/doorbell_decoder_chk.sv
module doorbell_decoder_chk
    import db_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int ADDR_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic                   cfg_en,
    input logic [NUM_Q*PTR_W-1:0] sq_tail_out,
    input logic [NUM_Q*PTR_W-1:0] cq_head_out,
    input logic [NUM_Q-1:0]       sq_kick,
    input logic [NUM_Q-1:0]       cq_irq
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(DB_BASE);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(cfg_en)) |-> ($stable(sq_tail_out) && $stable(cq_head_out) && sq_kick == '0 && cq_irq == '0)) // R12
        else $error("idle cycle moved state or pulsed");

    AST_MISALIGNED_DROP: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_addr[1:0] != 2'b00 && !cfg_en) |-> ($stable(sq_tail_out) && $stable(cq_head_out) && sq_kick == '0 && cq_irq == '0)) // R4
        else $error("misaligned write had an effect");

    AST_BELOW_WINDOW_DROP: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_addr < BASE_A && !cfg_en) |-> ($stable(sq_tail_out) && $stable(cq_head_out) && sq_kick == '0 && cq_irq == '0)) // R5
        else $error("write below window had an effect");

    AST_IRQ_FROM_HEAD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cq_irq != '0) |-> $past(wr_en && wr_addr[2]))  // R10
        else $error("interrupt without a head doorbell");

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cq_irq))  // R10
        else $error("more than one interrupt at once");

    AST_TAIL_CAUSED: assert property (@(posedge clk) disable iff (rst)
        (sq_tail_out != $past(sq_tail_out)) |-> $past(wr_en || cfg_en))  // R2
        else $error("submission tail moved with no cause");

endmodule

bind doorbell_decoder doorbell_decoder_chk #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .cfg_en      (cfg_en),
    .sq_tail_out (sq_tail_out),
    .cq_head_out (cq_head_out),
    .sq_kick     (sq_kick),
    .cq_irq      (cq_irq)
);

// File: tb/doorbell_decoder_test.sv
module doorbell_decoder_test;

    localparam int NQ = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [15:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          cfg_en = 1'b0;
    logic          cfg_is_cq = 1'b0;
    logic          cfg_create = 1'b0;
    logic [1:0]    cfg_qid = '0;
    logic [15:0]   cfg_size = '0;
    logic [1:0]    cfg_cqid = '0;
    logic [15:0]   ct [NQ];
    logic [NQ*16-1:0] cq_tail_in;
    logic [NQ*16-1:0] sq_tail_out, cq_head_out;
    logic [NQ-1:0] sq_kick, cq_irq;

    assign cq_tail_in = {ct[3], ct[2], ct[1], ct[0]};

    always #4 clk = ~clk;

    doorbell_decoder #(.NUM_Q(NQ), .ADDR_W(16)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_en(cfg_en), .cfg_is_cq(cfg_is_cq), .cfg_create(cfg_create), .cfg_qid(cfg_qid),
        .cfg_size(cfg_size), .cfg_cqid(cfg_cqid), .cq_tail_in(cq_tail_in),
        .sq_tail_out(sq_tail_out), .cq_head_out(cq_head_out), .sq_kick(sq_kick), .cq_irq(cq_irq)
    );

    typedef struct {
        logic [NQ*16-1:0] sq;
        logic [NQ*16-1:0] cq;
        logic [NQ-1:0]    kick;
        logic [NQ-1:0]    irq;
        string            tag;
    } exp_t;

    exp_t sb[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // requirement-level model of the queue records
    bit          m_sv [NQ];
    bit          m_cv [NQ];
    logic [15:0] m_ss [NQ];
    logic [15:0] m_cs [NQ];
    logic [15:0] m_st [NQ];
    logic [15:0] m_ch [NQ];
    int          m_sb [NQ];

    function automatic logic [NQ*16-1:0] pack_sq();
        logic [NQ*16-1:0] v;
        for (int i = 0; i < NQ; i++) v[i*16 +: 16] = m_st[i];
        return v;
    endfunction

    function automatic logic [NQ*16-1:0] pack_cq();
        logic [NQ*16-1:0] v;
        for (int i = 0; i < NQ; i++) v[i*16 +: 16] = m_ch[i];
        return v;
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(string tag, logic [NQ-1:0] k, logic [NQ-1:0] q);
        exp_t e;
        e.sq = pack_sq();
        e.cq = pack_cq();
        e.kick = k;
        e.irq = q;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        wr_en = 1'b0;
        cfg_en = 1'b0;
        push(tag, '0, '0);
    endtask

    task automatic cfg_op(string tag, bit is_cq, bit create, int q, int size, int cqid);
        @(negedge clk);
        wr_en = 1'b0;
        cfg_en = 1'b1;
        cfg_is_cq = is_cq;
        cfg_create = create;
        cfg_qid = 2'(q);
        cfg_size = 16'(size);
        cfg_cqid = 2'(cqid);
        if (is_cq) begin
            m_cv[q] = create; m_cs[q] = 16'(size); m_ch[q] = '0;
        end else begin
            m_sv[q] = create; m_ss[q] = 16'(size); m_st[q] = '0; m_sb[q] = cqid;
        end
        push(tag, '0, '0);
    endtask

    task automatic db_write(string tag, logic [15:0] addr, logic [31:0] data);
        logic [NQ-1:0] k;
        logic [NQ-1:0] ir;
        logic [15:0]   off;
        logic [15:0]   p;
        int            q;
        bit            full;
        k = '0;
        ir = '0;
        @(negedge clk);
        cfg_en = 1'b0;
        wr_en = 1'b1;
        wr_addr = addr;
        wr_data = data;
        p = data[15:0];
        if (addr >= 16'h1000 && addr[1:0] == 2'b00) begin
            off = addr - 16'h1000;
            q = int'(off >> 3);
            if (q < NQ) begin
                if (!off[2]) begin
                    if (m_sv[q] && p < m_ss[q]) begin
                        m_st[q] = p;
                        k[q] = 1'b1;
                    end
                end else if (m_cv[q] && p < m_cs[q]) begin
                    full = (((32'(ct[q]) + 1) % 32'(m_cs[q])) == 32'(m_ch[q]));
                    m_ch[q] = p;
                    ir[q] = (p != ct[q]);
                    if (full) begin
                        for (int j = 0; j < NQ; j++)
                            if (m_sv[j] && m_sb[j] == q) k[j] = 1'b1;
                    end
                end
            end
        end
        push(tag, k, ir);
    endtask

    // monitor: compare each scoreboard entry two time units after the edge
    always @(posedge clk) begin
        #2;
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "sq_tail_out", 64'(sq_tail_out), 64'(e.sq));
            check(e.tag, "cq_head_out", 64'(cq_head_out), 64'(e.cq));
            check(e.tag, "sq_kick",     64'(sq_kick),     64'(e.kick));
            check(e.tag, "cq_irq",      64'(cq_irq),      64'(e.irq));
        end
    end

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin
            ct[i] = '0; m_sv[i] = 0; m_cv[i] = 0; m_ss[i] = '0; m_cs[i] = '0;
            m_st[i] = '0; m_ch[i] = '0; m_sb[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "sq_tail_out", 64'(sq_tail_out), 64'd0);
        check("R1", "cq_head_out", 64'(cq_head_out), 64'd0);
        check("R1", "pulses", 64'({sq_kick, cq_irq}), 64'd0);
        db_write("R1", 16'h1000, 32'd1);
        db_write("R1", 16'h1004, 32'd1);
        idle("R12");

        // R11: create queues
        cfg_op("R11", 1, 1, 0, 8, 0);
        cfg_op("R11", 1, 1, 1, 4, 0);
        cfg_op("R11", 0, 1, 0, 8, 0);
        cfg_op("R11", 0, 1, 1, 5, 1);
        cfg_op("R11", 0, 1, 2, 3, 1);
        idle("R12");

        // R2 / R8: tail writes
        db_write("R2", 16'h1008, 32'd3);
        idle("R12");
        db_write("R8", 16'h1010, 32'hABCD_0002);
        idle("R12");
        // R7: pointer at or above the entry count
        db_write("R7", 16'h1008, 32'd5);
        db_write("R7", 16'h1010, 32'd4);
        // R4, R5, R6
        db_write("R4", 16'h100A, 32'd1);
        db_write("R4", 16'h1001, 32'd1);
        db_write("R5", 16'h0008, 32'd1);
        db_write("R6", 16'h1020, 32'd1);
        db_write("R6", 16'h1018, 32'd1);
        idle("R12");

        // R3 / R10: head writes with tail = 2
        ct[1] = 16'd2;
        db_write("R3", 16'h100C, 32'd1);
        idle("R12");
        db_write("R10", 16'h100C, 32'd2);
        idle("R12");
        // R9: queue full (tail 1, head 2) -> both bound submission queues kicked
        ct[1] = 16'd1;
        db_write("R9", 16'h100C, 32'd3);
        idle("R12");
        // R11 + R9: deleted queue is not kicked on restart
        cfg_op("R11", 0, 0, 2, 3, 1);
        ct[1] = 16'd2;
        db_write("R9", 16'h100C, 32'd0);
        idle("R12");
        db_write("R11", 16'h1010, 32'd1);
        // R11: delete completion queue 1, head write dropped
        cfg_op("R11", 1, 0, 1, 4, 0);
        db_write("R11", 16'h100C, 32'd1);
        // R10: head equal to tail, no interrupt, and not full -> no kick
        db_write("R10", 16'h1004, 32'd0);
        // R11: recreate with fresh pointer
        db_write("R2", 16'h1000, 32'd7);
        cfg_op("R11", 0, 1, 0, 6, 0);
        db_write("R2", 16'h1000, 32'd5);
        idle("R12");
        idle("R12");
        repeat (3) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule